// File: doc/BRIEF.md
# Page-register address extension unit

This block widens a 16-bit virtual data address into a 22-bit physical address. Four 8-bit page registers each own a quarter of the virtual space. The top two bits of a virtual address pick a register. That register's page number is placed above the low 14 address bits, so any 16-Kbyte window can point at any of 256 pages in a 4-Mbyte space.

A CPU loads the page registers through a simple write port. A translate request is a virtual address with a valid strobe. The physical address and a valid flag come back one clock later.

A bypass input serves an alternate transfer mode. While it is set, the page registers play no part, and a caller-supplied 6-bit segment is placed above the full 16-bit address. The block also raises a hazard flag when a page register is rewritten by an access whose own address lies in that register's window.

Top module: `pg_ext_unit`

## Requirements
- R1: After reset, rsp_valid_o, hazard_o and rsp_addr_o are all 0, and page register n holds page number n, so virtual addresses 0000h-FFFFh map one-to-one onto physical 000000h-00FFFFh.
- R2: Virtual address bits [15:14] select the page register: 0 selects register 0 (window 0000h-3FFFh), 1 selects register 1 (4000h-7FFFh), 2 selects register 2 (8000h-BFFFh) and 3 selects register 3 (C000h-FFFFh).
- R3: Outside bypass mode, rsp_addr_o[21:14] is the selected page number and rsp_addr_o[13:0] equals virtual address bits [13:0].
- R4: A write with wr_en_i=1 stores wr_data_i into the register given by wr_sel_i at the clock edge. A translation sampled at that same edge still uses the old value, and the next one uses the new value.
- R5: rsp_valid_o is req_valid_i delayed by exactly one clock. When req_valid_i is 0, rsp_addr_o keeps its previous value.
- R6: With dma_bypass_i=1, rsp_addr_o is {dma_seg_i, req_addr_i} (segment in bits [21:16]), whatever the page registers hold.
- R7: When wr_en_i=1 and wr_src_addr_i[15:14] equals wr_sel_i, hazard_o is 1 in the following cycle. The write is still carried out.
- R8: hazard_o is 0 in the cycle after any cycle in which wr_en_i=0, or in which wr_src_addr_i[15:14] differs from wr_sel_i.
- R9: A write changes only the register selected by wr_sel_i. The other three registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Page register write enable |
| wr_sel_i | input | 2 | Index of the register to write |
| wr_data_i | input | 8 | Page number to store |
| wr_src_addr_i | input | 16 | Virtual address of the access performing the write |
| req_valid_i | input | 1 | Translate request strobe |
| req_addr_i | input | 16 | Virtual address to translate |
| dma_bypass_i | input | 1 | Selects segment bypass instead of page translation |
| dma_seg_i | input | 6 | Segment used in bypass mode |
| rsp_valid_o | output | 1 | Translated address valid, one cycle after the request |
| rsp_addr_o | output | 22 | Physical address |
| hazard_o | output | 1 | A page register was written through its own window in the previous cycle |

## Verification
Addresses are translated at both edges of every window (0000h, 3FFFh, 4000h, C000h, FFFFh), which shows whether the select bits and the offset bits are split at the right place. Page values with the top and bottom bits set (FFh, 80h, A5h, 11h) tell a correct concatenation from a shifted or truncated one. A write paired with a same-cycle read of the same register separates the old value from the new one. Writes whose source address is in the same window and in a different window, and bypass requests made after the page registers have been changed, show that the hazard compare and the segment path each look only at their own inputs.

// File: rtl/pg_ext_pkg.sv
package pg_ext_pkg;
  localparam int unsigned VA_W      = 16;
  localparam int unsigned PAGE_W    = 8;
  localparam int unsigned NUM_PAGES = 4;
  localparam int unsigned SEG_W     = 6;
  localparam int unsigned SEL_W     = $clog2(NUM_PAGES);
  localparam int unsigned OFF_W     = VA_W - SEL_W;
  localparam int unsigned PA_W      = PAGE_W + OFF_W;
endpackage

// File: rtl/pg_ext_pagefile.sv
module pg_ext_pagefile #(
  parameter int unsigned NUM_PAGES = pg_ext_pkg::NUM_PAGES,
  parameter int unsigned PAGE_W    = pg_ext_pkg::PAGE_W,
  parameter int unsigned SEL_W     = pg_ext_pkg::SEL_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [SEL_W-1:0]                wr_sel_i,
  input  logic [PAGE_W-1:0]               wr_data_i,
  output logic [NUM_PAGES-1:0][PAGE_W-1:0] page_o
);

  // reset value of register n is page n: identity map of the low window set
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    logic [PAGE_W-1:0] page_q;
    logic              hit;

    assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  page_q <= PAGE_W'(g);
      else if (hit) page_q <= wr_data_i;
    end

    assign page_o[g] = page_q;
  end

endmodule

// File: rtl/pg_ext_xlate.sv
module pg_ext_xlate #(
  parameter int unsigned NUM_PAGES = pg_ext_pkg::NUM_PAGES,
  parameter int unsigned PAGE_W    = pg_ext_pkg::PAGE_W,
  parameter int unsigned VA_W      = pg_ext_pkg::VA_W,
  parameter int unsigned SEG_W     = pg_ext_pkg::SEG_W,
  parameter int unsigned PA_W      = pg_ext_pkg::PA_W
) (
  input  logic [NUM_PAGES-1:0][PAGE_W-1:0] page_i,
  input  logic [VA_W-1:0]                  va_i,
  input  logic                             bypass_i,
  input  logic [SEG_W-1:0]                 seg_i,
  output logic [PA_W-1:0]                  pa_o
);

  localparam int unsigned SEL_W = $clog2(NUM_PAGES);
  localparam int unsigned OFF_W = VA_W - SEL_W;

  logic [SEL_W-1:0]  sel;
  logic [PAGE_W-1:0] page;
  logic [PA_W-1:0]   paged_pa;
  logic [PA_W-1:0]   seg_pa;

  assign sel      = va_i[VA_W-1 -: SEL_W];
  assign page     = page_i[sel];
  assign paged_pa = PA_W'({page, va_i[OFF_W-1:0]});
  assign seg_pa   = PA_W'({seg_i, va_i});
  assign pa_o     = bypass_i ? seg_pa : paged_pa;

endmodule

// File: rtl/pg_ext_hazard.sv
module pg_ext_hazard #(
  parameter int unsigned VA_W  = pg_ext_pkg::VA_W,
  parameter int unsigned SEL_W = pg_ext_pkg::SEL_W
) (
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [VA_W-1:0]  wr_src_addr_i,
  output logic             hit_o
);

  // writer's own window equals the register it rewrites
  assign hit_o = wr_en_i && (wr_src_addr_i[VA_W-1 -: SEL_W] == wr_sel_i);

endmodule

// File: rtl/pg_ext_unit.sv
module pg_ext_unit #(
  parameter int unsigned NUM_PAGES = pg_ext_pkg::NUM_PAGES,
  parameter int unsigned PAGE_W    = pg_ext_pkg::PAGE_W,
  parameter int unsigned VA_W      = pg_ext_pkg::VA_W,
  parameter int unsigned SEG_W     = pg_ext_pkg::SEG_W,
  parameter int unsigned SEL_W     = $clog2(NUM_PAGES),
  parameter int unsigned PA_W      = PAGE_W + VA_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [PAGE_W-1:0] wr_data_i,
  input  logic [VA_W-1:0]   wr_src_addr_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_addr_i,
  input  logic              dma_bypass_i,
  input  logic [SEG_W-1:0]  dma_seg_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_addr_o,
  output logic              hazard_o
);

  logic [NUM_PAGES-1:0][PAGE_W-1:0] page;
  logic [PA_W-1:0]                  pa_d;
  logic                             hz_d;

  logic            rsp_valid_q;
  logic [PA_W-1:0] rsp_addr_q;
  logic            hazard_q;

  pg_ext_pagefile #(
    .NUM_PAGES(NUM_PAGES),
    .PAGE_W   (PAGE_W),
    .SEL_W    (SEL_W)
  ) u_pagefile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .page_o   (page)
  );

  pg_ext_xlate #(
    .NUM_PAGES(NUM_PAGES),
    .PAGE_W   (PAGE_W),
    .VA_W     (VA_W),
    .SEG_W    (SEG_W),
    .PA_W     (PA_W)
  ) u_xlate (
    .page_i  (page),
    .va_i    (req_addr_i),
    .bypass_i(dma_bypass_i),
    .seg_i   (dma_seg_i),
    .pa_o    (pa_d)
  );

  pg_ext_hazard #(
    .VA_W (VA_W),
    .SEL_W(SEL_W)
  ) u_hazard (
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_src_addr_i(wr_src_addr_i),
    .hit_o        (hz_d)
  );

  // translation samples pre-write page values: same-cycle write seen next request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_addr_q  <= '0;
      hazard_q    <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      hazard_q    <= hz_d;
      if (req_valid_i) rsp_addr_q <= pa_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_addr_o  = rsp_addr_q;
  assign hazard_o    = hazard_q;

endmodule

// File: rtl/pg_ext_unit_checker.sv
module pg_ext_unit_checker #(
  parameter int unsigned PAGE_W = pg_ext_pkg::PAGE_W,
  parameter int unsigned VA_W   = pg_ext_pkg::VA_W,
  parameter int unsigned SEG_W  = pg_ext_pkg::SEG_W,
  parameter int unsigned SEL_W  = pg_ext_pkg::SEL_W,
  parameter int unsigned PA_W   = pg_ext_pkg::PA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic [PAGE_W-1:0] wr_data_i,
  input logic [VA_W-1:0]   wr_src_addr_i,
  input logic              req_valid_i,
  input logic [VA_W-1:0]   req_addr_i,
  input logic              dma_bypass_i,
  input logic [SEG_W-1:0]  dma_seg_i,
  input logic              rsp_valid_o,
  input logic [PA_W-1:0]   rsp_addr_o,
  input logic              hazard_o
);

  localparam int unsigned OFF_W = VA_W - SEL_W;

  a_r5_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r5_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(rsp_addr_o));

  a_r3_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dma_bypass_i) |=>
      rsp_addr_o[OFF_W-1:0] == $past(req_addr_i[OFF_W-1:0]));

  a_r6_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dma_bypass_i) |=>
      rsp_addr_o == PA_W'({$past(dma_seg_i), $past(req_addr_i)}));

  // R4: a request right after a write to its register sees the written page
  a_r4_write_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && req_valid_i && !dma_bypass_i &&
     req_addr_i[VA_W-1 -: SEL_W] == $past(wr_sel_i)) |=>
      rsp_addr_o[PA_W-1 -: PAGE_W] == $past(wr_data_i, 2));

  a_r7_hazard_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_src_addr_i[VA_W-1 -: SEL_W] == wr_sel_i) |=> hazard_o);

  a_r8_hazard_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_src_addr_i[VA_W-1 -: SEL_W] == wr_sel_i) |=> !hazard_o);

endmodule

bind pg_ext_unit pg_ext_unit_checker #(
  .PAGE_W(PAGE_W),
  .VA_W  (VA_W),
  .SEG_W (SEG_W),
  .SEL_W (SEL_W),
  .PA_W  (PA_W)
) u_checker (.*);

// File: tb/pg_ext_unit_test.sv
module pg_ext_unit_test;

  typedef struct packed {
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [7:0]  wr_data;
    logic [15:0] wr_src;
    logic [15:0] va;
    logic        byp;
    logic [5:0]  seg;
    logic [21:0] exp_pa;
    logic        exp_hz;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'h0000, 1'b0, 6'h00, 22'h000000, 1'b0},
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'h7FFF, 1'b0, 6'h00, 22'h007FFF, 1'b0},
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'hC123, 1'b0, 6'h00, 22'h00C123, 1'b0},
    '{1'b1, 2'd2, 8'hA5, 16'h0100, 16'h8004, 1'b0, 6'h00, 22'h008004, 1'b0},
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'h8004, 1'b0, 6'h00, 22'h294004, 1'b0},
    '{1'b1, 2'd0, 8'hFF, 16'h0010, 16'h4001, 1'b0, 6'h00, 22'h004001, 1'b1},
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'h0002, 1'b0, 6'h00, 22'h3FC002, 1'b0},
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'h1234, 1'b1, 6'h2A, 22'h2A1234, 1'b0},
    '{1'b1, 2'd3, 8'h11, 16'hC000, 16'hFFFF, 1'b1, 6'h3F, 22'h3FFFFF, 1'b1},
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'hFFFF, 1'b0, 6'h00, 22'h047FFF, 1'b0},
    '{1'b0, 2'd0, 8'h00, 16'h0000, 16'h5555, 1'b0, 6'h00, 22'h005555, 1'b0},
    '{1'b1, 2'd1, 8'h80, 16'h4000, 16'h3FFF, 1'b0, 6'h00, 22'h3FFFFF, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] wr_src = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        byp = 1'b0;
  logic [5:0]  seg = '0;
  logic        rsp_valid;
  logic [21:0] rsp_addr;
  logic        hazard;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pg_ext_unit uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .wr_src_addr_i(wr_src),
    .req_valid_i  (req_valid),
    .req_addr_i   (req_addr),
    .dma_bypass_i (byp),
    .dma_seg_i    (seg),
    .rsp_valid_o  (rsp_valid),
    .rsp_addr_o   (rsp_addr),
    .hazard_o     (hazard)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] ws, input logic [7:0] wd,
                       input logic [15:0] src, input logic rv, input logic [15:0] va,
                       input logic b, input logic [5:0] s);
    wr_en = we; wr_sel = ws; wr_data = wd; wr_src = src;
    req_valid = rv; req_addr = va; byp = b; seg = s;
  endtask

  // drive at negedge, one posedge registers, sample at following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 valid at reset", 32'(rsp_valid), 32'd0);
    check("R1 addr at reset", 32'(rsp_addr), 32'd0);
    check("R1 hazard at reset", 32'(hazard), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4/R6/R7/R8/R9 vector walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].wr_en, VEC[i].wr_sel, VEC[i].wr_data, VEC[i].wr_src,
            1'b1, VEC[i].va, VEC[i].byp, VEC[i].seg);
      step();
      check($sformatf("R5 valid vec %0d", i), 32'(rsp_valid), 32'd1);
      check($sformatf("R2/R3/R4/R6/R9 addr vec %0d", i), 32'(rsp_addr), 32'(VEC[i].exp_pa));
      check($sformatf("R7/R8 hazard vec %0d", i), 32'(hazard), 32'(VEC[i].exp_hz));
    end

    // R5 idle cycle: valid drops, address holds
    drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 6'h00);
    step();
    check("R5 valid idle", 32'(rsp_valid), 32'd0);
    check("R5 addr hold", 32'(rsp_addr), 32'h3FFFFF);

    // R8 write from a different window: no hazard, write applied
    drive(1'b1, 2'd2, 8'h3C, 16'hC000, 1'b0, 16'h0000, 1'b0, 6'h00);
    step();
    check("R8 cross-window write", 32'(hazard), 32'd0);
    drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 16'hBFFF, 1'b0, 6'h00);
    step();
    check("R4 write visible", 32'(rsp_addr), 32'h0F3FFF);
    check("R8 no write no hazard", 32'(hazard), 32'd0);

    // R6 bypass ignores altered page registers
    drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 16'h8000, 1'b1, 6'h01);
    step();
    check("R6 bypass", 32'(rsp_addr), 32'h018000);

    // R1 reset mid-run restores identity map
    drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 6'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 16'hBFFF, 1'b0, 6'h00);
    step();
    check("R1 identity after reset p2", 32'(rsp_addr), 32'h00BFFF);
    drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b1, 16'h0000, 1'b0, 6'h00);
    step();
    check("R1 identity after reset p0", 32'(rsp_addr), 32'h000000);
    drive(1'b0, 2'd0, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 6'h00);
    step();
    finish_run();
  end

endmodule